// File: doc/BRIEF.md
# Carry-select adder with increment-derived alternates

This block adds two 128-bit unsigned operands and a carry-in in a single combinational path, giving a 128-bit sum and a carry-out. The operand bits are cut into groups of unequal width. The bottom group is a plain ripple-carry adder that takes the external carry-in. Every higher group computes its slice once, with its carry-in forced to zero. An incrementer that is one bit wider than the group then adds one to that result, which gives the carry-in-of-one alternative without a second ripple adder.

A 2:1 select, driven by the carry that leaves the group below, picks one of the two results for each group. Group widths grow toward the most significant end. Each group's own ripple then finishes at about the time its select carry arrives through the chain of selects below it.

The group widths are a parameter list. The default tiling is 2, 2, 3, 4, 5, 7, 8, 9, 10, 11, 12, 13, 13, 14 and 15 bits, starting from bit 0. Elaboration stops with an error if the list does not add up to the data width or if any width is smaller than the one before it.

Top module: `csel_bec_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals the 129-bit unsigned value a + b + cin.
- R2: Sum bits [1:0] equal the low two bits of a[1:0] + b[1:0] + cin, with cin feeding the bottom group directly.
- R3: When a XOR b is all ones, the carry travels the full width: cin = 1 gives sum = 0 and cout = 1, and cin = 0 gives sum = all ones and cout = 0.
- R4: A carry produced at the top bit of any group enters the next group. The default group boundaries are at bits 2, 4, 7, 11, 16, 23, 31, 40, 50, 61, 73, 86, 99 and 113. Setting bit (boundary-1) in both a and b, with cin = 0, sets sum bit (boundary) and clears everything below it.
- R5: With a and b both all ones, sum equals all ones shifted left by one with cin in bit 0, and cout = 1.
- R6: With a = b = 0, sum equals cin zero-extended and cout = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 128 | First operand, unsigned |
| b | input | 128 | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 128 | Low 128 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 127 |

## Verification
The hardest case to reach is a carry that starts low and must cross many groups in a row. Each group must then pick its incremented result solely because the group below selected a carry. Uniform random operands almost never produce a propagate run longer than a handful of bits. The stimulus therefore drives complementary operands with carry-in set, places a generated carry exactly at each group boundary, and builds a run of ones from bit 0 up to each boundary with carry-in set. Random vectors with both carry-in values cover the rest.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int unsigned CSEL_DATA_W  = 128;
    localparam int unsigned CSEL_NUM_GRP = 15;

    typedef struct packed {
        logic s;
        logic c;
    } fa_out_t;

    typedef enum logic {
        SEL_PLAIN = 1'b0,
        SEL_INCR  = 1'b1
    } sel_e;

    function automatic fa_out_t full_add(logic x, logic y, logic ci);
        fa_out_t r;
        r.s = x ^ y ^ ci;
        r.c = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

endpackage

// File: rtl/csel_rca.sv
module csel_rca #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    import csel_pkg::*;

    logic [W:0] chain;
    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        fa_out_t r;
        assign r          = full_add(a[i], b[i], chain[i]);
        assign sum[i]     = r.s;
        assign chain[i+1] = r.c;
    end

    assign cout = chain[W];

endmodule

// File: rtl/csel_bec.sv
module csel_bec #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] din,
    input  logic         cin_hi,
    output logic [W-1:0] dout,
    output logic         cout
);
    // prefix AND of the lower bits decides which bits flip on +1
    logic [W:0] ones_below;
    assign ones_below[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i]         = din[i] ^ ones_below[i];
        assign ones_below[i+1] = ones_below[i] & din[i];
    end

    assign cout = cin_hi | ones_below[W];

endmodule

// File: rtl/csel_group.sv
module csel_group #(
    parameter int unsigned W     = 4,
    parameter bit          FIRST = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    import csel_pkg::*;

    if (FIRST) begin : g_base
        csel_rca #(.W(W)) u_rca (
            .a    (a),
            .b    (b),
            .cin  (cin),
            .sum  (sum),
            .cout (cout)
        );
    end else begin : g_select
        logic [W-1:0] s_plain;
        logic         c_plain;
        logic [W-1:0] s_incr;
        logic         c_incr;
        sel_e         pick;

        csel_rca #(.W(W)) u_rca (
            .a    (a),
            .b    (b),
            .cin  (1'b0),
            .sum  (s_plain),
            .cout (c_plain)
        );

        csel_bec #(.W(W)) u_bec (
            .din    (s_plain),
            .cin_hi (c_plain),
            .dout   (s_incr),
            .cout   (c_incr)
        );

        assign pick = cin ? SEL_INCR : SEL_PLAIN;

        always_comb begin
            if (pick == SEL_INCR) begin
                sum  = s_incr;
                cout = c_incr;
            end else begin
                sum  = s_plain;
                cout = c_plain;
            end
        end
    end

endmodule

// File: rtl/csel_bec_adder.sv
module csel_bec_adder #(
    parameter int unsigned DATA_W         = csel_pkg::CSEL_DATA_W,
    parameter int unsigned NUM_GRP        = csel_pkg::CSEL_NUM_GRP,
    parameter int unsigned GRP_W [NUM_GRP] =
        '{2, 2, 3, 4, 5, 7, 8, 9, 10, 11, 12, 13, 13, 14, 15}
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);

    function automatic int unsigned lsb_of(int unsigned k);
        int unsigned acc = 0;
        for (int unsigned j = 0; j < k; j++) acc += GRP_W[j];
        return acc;
    endfunction

    function automatic bit widths_rise();
        bit ok = 1'b1;
        for (int unsigned j = 1; j < NUM_GRP; j++)
            if (GRP_W[j] < GRP_W[j-1]) ok = 1'b0;
        return ok;
    endfunction

    localparam int unsigned TOTAL_W = lsb_of(NUM_GRP);
    localparam bit          RISING  = widths_rise();

    if (TOTAL_W != DATA_W) begin : g_bad_total
        $error("group widths sum to %0d, expected %0d", TOTAL_W, DATA_W);
    end
    if (!RISING) begin : g_bad_order
        $error("group widths must be non-decreasing toward the MSB");
    end

    logic [NUM_GRP-1:0] grp_c;

    for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
        localparam int unsigned LSB = lsb_of(k);
        localparam int unsigned W   = GRP_W[k];
        logic ci;

        if (k == 0) begin : g_ci_ext
            assign ci = cin;
        end else begin : g_ci_chain
            assign ci = grp_c[k-1];
        end

        csel_group #(.W(W), .FIRST(k == 0)) u_grp (
            .a    (a[LSB +: W]),
            .b    (b[LSB +: W]),
            .cin  (ci),
            .sum  (sum[LSB +: W]),
            .cout (grp_c[k])
        );
    end

    assign cout = grp_c[NUM_GRP-1];

endmodule

// File: rtl/csel_bec_adder_chk.sv
module csel_bec_adder_chk #(
    parameter int unsigned DATA_W         = 128,
    parameter int unsigned NUM_GRP        = 15,
    parameter int unsigned GRP_W [NUM_GRP] =
        '{2, 2, 3, 4, 5, 7, 8, 9, 10, 11, 12, 13, 13, 14, 15}
) (
    input logic [DATA_W-1:0]  a,
    input logic [DATA_W-1:0]  b,
    input logic               cin,
    input logic [DATA_W-1:0]  sum,
    input logic               cout,
    input logic [NUM_GRP-1:0] grp_c
);
    logic [DATA_W:0] full_ref;
    logic [DATA_W:0] mask;
    logic [DATA_W:0] part;
    logic [1:0]      low_ref;
    int unsigned     edge_pos;

    always_comb begin
        full_ref = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        low_ref  = a[1:0] + b[1:0] + {1'b0, cin};

        AST_SUM_EXACT: assert ({cout, sum} == full_ref);            // R1
        AST_LOW_PAIR: assert (sum[1:0] == low_ref);                  // R2
        if ((a ^ b) == {DATA_W{1'b1}}) begin
            AST_FULL_PROP: assert (cout == cin && sum == {DATA_W{~cin}}); // R3
        end
        if (a == '0 && b == '0) begin
            AST_ZERO_IN: assert (!cout && sum == {{(DATA_W-1){1'b0}}, cin}); // R6
        end

        edge_pos = 0;
        mask     = '0;
        part     = '0;
        for (int unsigned k = 0; k < NUM_GRP; k++) begin
            edge_pos = edge_pos + GRP_W[k];
            mask     = ({{DATA_W{1'b0}}, 1'b1} << edge_pos) - 1'b1;
            part     = ({1'b0, a} & mask) + ({1'b0, b} & mask)
                     + {{DATA_W{1'b0}}, cin};
            AST_GRP_CARRY: assert (grp_c[k] == part[edge_pos]);      // R4
        end
    end

endmodule

bind csel_bec_adder csel_bec_adder_chk #(
    .DATA_W  (DATA_W),
    .NUM_GRP (NUM_GRP),
    .GRP_W   (GRP_W)
) u_chk (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .grp_c (grp_c)
);

// File: tb/csel_bec_adder_bench.sv
module csel_bec_adder_bench;

    localparam int W = 128;
    localparam int NB = 14;
    localparam int BND [NB] = '{2, 4, 7, 11, 16, 23, 31, 40, 50, 61, 73, 86, 99, 113};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    csel_bec_adder u_csel_bec_adder (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    function automatic logic [W-1:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        @(negedge clk);
        a   = x;
        b   = y;
        cin = c;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W:0] exp);
        checks++;
        if ({cout, sum} !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%0b got=%h exp=%h",
                     req, a, b, cin, {cout, sum}, exp);
        end
    endtask

    task automatic check_low(input string req, input logic [1:0] exp);
        checks++;
        if (sum[1:0] !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b", req, sum[1:0], exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20241));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R6: zero operands, both carry-in values (first is the rest state)
        apply('0, '0, 1'b0);
        check("R6", {(W+1){1'b0}});
        apply('0, '0, 1'b1);
        check("R6", {{W{1'b0}}, 1'b1});

        // R3: complementary operands, full-width propagate
        for (int c = 0; c < 2; c++) begin
            logic [W-1:0] x;
            x = rnd128();
            apply(x, ~x, 1'(c));
            check("R3", c ? {1'b1, {W{1'b0}}} : {1'b0, {W{1'b1}}});
            apply({W{1'b1}}, '0, 1'(c));
            check("R3", c ? {1'b1, {W{1'b0}}} : {1'b0, {W{1'b1}}});
        end

        // R5: both all ones
        for (int c = 0; c < 2; c++) begin
            apply({W{1'b1}}, {W{1'b1}}, 1'(c));
            check("R5", {1'b1, {(W-1){1'b1}}, 1'(c)});
        end

        // R4: generated carry at each group boundary, and a run of ones reaching it
        for (int k = 0; k < NB; k++) begin
            logic [W-1:0] bit_in;
            logic [W-1:0] run;
            bit_in = {{(W-1){1'b0}}, 1'b1} << (BND[k] - 1);
            run    = ({{(W-1){1'b0}}, 1'b1} << BND[k]) - 1'b1;
            apply(bit_in, bit_in, 1'b0);
            check("R4", {1'b0, bit_in << 1});
            apply(run, '0, 1'b1);
            check("R4", {1'b0, run + 1'b1});
        end

        // R2: low pair exhaustive
        for (int v = 0; v < 32; v++) begin
            logic [1:0] xa, xb;
            logic       xc;
            xa = 2'(v);
            xb = 2'(v >> 2);
            xc = 1'(v >> 4);
            apply({rnd128()} & ~128'h3 | {126'b0, xa}, {rnd128()} & ~128'h3 | {126'b0, xb}, xc);
            check_low("R2", 2'(xa + xb + {1'b0, xc}));
        end

        // R1: random operands, both carry-in values, plus sparse and dense patterns
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] x, y;
            logic c;
            x = rnd128();
            y = rnd128();
            c = 1'($urandom());
            if (n % 4 == 1) y = ~x ^ ({{(W-1){1'b0}}, 1'b1} << ($urandom() % W));
            if (n % 4 == 2) x = x | rnd128();
            if (n % 4 == 3) y = y & rnd128() & rnd128();
            apply(x, y, c);
            check("R1", ref_add(x, y, c));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule